// File: doc/BRIEF.md
# Buffer Interrupt Flags with Receive Queue

This block keeps the per-buffer interrupt flags of a CAN-style message controller, along with a small receive queue that can take over the lowest eight buffers. With the queue mode off, every one of the 32 flag bits latches a completion pulse from its buffer. Software clears a flag by writing a one to it. With the queue mode on, incoming frames go into a six-entry first-in first-out store. Flag bits 5, 6 and 7 then report the queue's frame-ready, almost-full and frame-lost conditions, and bits 0 to 4 stay at zero.

The block also tells the acceptance filter which individual mask register applies to a given target. A target is either a message buffer or an element of the queue's filter table. The routing depends on the current mode. Every mode change empties the queue and clears the low eight flags, so stale status from one mode is never seen in the other.

Software reads the oldest queued frame from the head output. It releases that frame by writing a one to flag bit 5.

Top module: `can_mb_iflag`

## Requirements
- R1: After reset all 32 flag bits read 0, the queue is empty and the mode is buffer mode (queue off).
- R2: In buffer mode, a pulse on done bit i sets flag bit i one clock later, for every i in 0..31. In either mode the same holds for bits 8..31. Writing a 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R3: When a completion pulse and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R4: In queue mode, flag bits 0..4 read 0 and completion pulses on done bits 0..7 have no effect.
- R5: In queue mode, bit 5 reads 1 one clock after any cycle that leaves at least one frame stored, except as stated in R6.
- R6: In queue mode, writing 1 to bit 5 while frames are stored removes the oldest frame. Bit 5 then reads 0 for one cycle and returns to 1 on the next cycle if frames remain. The head output always shows the oldest stored frame, and frames leave in arrival order.
- R7: In queue mode, bit 6 sets only when a push with no removal moves the stored count from 3 to 4. It stays set until it is cleared, and it does not set again while the count stays at 4 or more.
- R8: In queue mode, a push with 6 frames stored and no removal in the same cycle drops the frame. The stored contents and count do not change, and bit 7 sets. A removal in the same cycle makes room, so the push is accepted.
- R9: A change of the mode input empties the queue and clears flag bits 0..7 at the next clock. Bits 8..31 are not affected. The new mode takes effect from that clock on.
- R10: In buffer mode, buffer target i selects mask i with valid 1, and a queue-filter target selects no mask (valid 0).
- R11: In queue mode, filter element e (0..7) selects mask e, buffer i (8..31) selects mask i, and buffer targets 0..7 and filter elements 8 and above give valid 0.
- R12: In buffer mode, push requests are ignored, so a later switch to queue mode finds the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | Mode select: 1 = queue mode, 0 = buffer mode |
| mb_done_i | input | 32 | Per-buffer completion pulses |
| rx_push_i | input | 1 | A received frame is offered to the queue |
| rx_frame_i | input | 16 | Frame payload offered with rx_push_i |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 32 | Write-one-to-clear data; bit 5 also releases the head frame in queue mode |
| tgt_fifo_i | input | 1 | Mask query target kind: 1 = queue filter element, 0 = buffer |
| tgt_idx_i | input | 5 | Mask query target index |
| flag_o | output | 32 | Interrupt flag register |
| fifo_head_o | output | 16 | Oldest stored frame (valid while bit 5 reads 1) |
| mask_vld_o | output | 1 | A mask register applies to the queried target |
| mask_idx_o | output | 5 | Index of the mask register that applies |

## Verification
Flags, the head frame and the queue state are all registered. Each of them changes on the first rising edge that samples a stimulus. The one exception is bit 5 after a release, which reads 0 at that edge and comes back one edge later. Mask routing is combinational from the query inputs, but it follows the mode one edge after fifo_en_i changes. The bench drives inputs on falling edges and compares every output just after the drive, against a model stepped once per rising edge. Each registered result is therefore checked exactly one edge after its stimulus, and each routing result in the same cycle as its query.

// File: rtl/can_iflag_pkg.sv
package can_iflag_pkg;
  localparam int unsigned AVAIL_BIT = 5;
  localparam int unsigned WARN_BIT  = 6;
  localparam int unsigned OVF_BIT   = 7;

  typedef enum logic {
    MODE_MB   = 1'b0,
    MODE_FIFO = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/can_rxf_store.sv
module can_rxf_store #(
  parameter int unsigned DEPTH    = 6,
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned WARN_LVL = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [WIDTH-1:0]             data_i,
  input  logic                         pop_i,
  output logic [WIDTH-1:0]             head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         nonempty_next_o,
  output logic                         pop_ok_o,
  output logic                         warn_evt_o,
  output logic                         ovf_evt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = pop_i && !flush_i && (cnt_q != '0);
  // a same-cycle removal frees a slot for the push
  assign push_ok = push_i && !flush_i && ((cnt_q != CNT_W'(DEPTH)) || pop_ok);

  always_comb begin
    if (flush_i) cnt_d = '0;
    else begin
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush_i) begin
        rd_q <= '0;
        wr_q <= '0;
      end else begin
        if (pop_ok)  rd_q <= ptr_inc(rd_q);
        if (push_ok) wr_q <= ptr_inc(wr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  assign head_o          = mem_q[rd_q];
  assign count_o         = cnt_q;
  assign nonempty_next_o = (cnt_d != '0);
  assign pop_ok_o        = pop_ok;
  assign warn_evt_o      = push_ok && !pop_ok && (cnt_q == CNT_W'(WARN_LVL-1));
  assign ovf_evt_o       = push_i && !flush_i && !push_ok;

  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_ovf_only_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |=> cnt_q == CNT_W'(DEPTH));
  assert_flush_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
  assert_warn_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_evt_o |=> cnt_q == CNT_W'(WARN_LVL));
endmodule

// File: rtl/can_iflag_reg.sv
module can_iflag_reg
  import can_iflag_pkg::*;
#(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned LOW_MB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_mode_i,
  input  logic              mode_chg_i,
  input  logic [NUM_MB-1:0] done_i,
  input  logic [NUM_MB-1:0] clr_i,
  input  logic              avail_i,
  input  logic              warn_evt_i,
  input  logic              ovf_evt_i,
  output logic [NUM_MB-1:0] flag_o
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
    logic bit_q;
    assign flag_o[i] = bit_q;

    if (i >= LOW_MB) begin : g_mb
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= done_i[i] | (bit_q & ~clr_i[i]);
      end

      assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i[i] |=> bit_q);
      assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!done_i[i] && clr_i[i]) |=> !bit_q);
    end else begin : g_low
      logic fifo_d;
      if (i == AVAIL_BIT) begin : g_avail
        assign fifo_d = avail_i;
      end else if (i == WARN_BIT) begin : g_warn
        assign fifo_d = warn_evt_i | (bit_q & ~clr_i[i]);
      end else if (i == OVF_BIT) begin : g_ovf
        assign fifo_d = ovf_evt_i | (bit_q & ~clr_i[i]);
      end else begin : g_rsvd
        assign fifo_d = 1'b0;
        assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
          fifo_mode_i |-> !bit_q);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          bit_q <= 1'b0;
        else if (mode_chg_i)  bit_q <= 1'b0;
        else if (fifo_mode_i) bit_q <= fifo_d;
        else                  bit_q <= done_i[i] | (bit_q & ~clr_i[i]);
      end
    end
  end

  assert_flush_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> flag_o[LOW_MB-1:0] == '0);
endmodule

// File: rtl/can_mask_route.sv
module can_mask_route #(
  parameter int unsigned NUM_MB     = 32,
  parameter int unsigned FILT_ELEMS = 8,
  parameter int unsigned LOW_MB     = 8,
  localparam int unsigned IDX_W     = $clog2(NUM_MB)
) (
  input  logic             fifo_mode_i,
  input  logic             tgt_fifo_i,
  input  logic [IDX_W-1:0] tgt_idx_i,
  output logic             mask_vld_o,
  output logic [IDX_W-1:0] mask_idx_o
);
  // masks are indexed 1:1 with their target; only ownership changes with mode
  always_comb begin
    mask_idx_o = tgt_idx_i;
    if (fifo_mode_i) begin
      if (tgt_fifo_i) mask_vld_o = ({1'b0, tgt_idx_i} < (IDX_W+1)'(FILT_ELEMS));
      else            mask_vld_o = ({1'b0, tgt_idx_i} >= (IDX_W+1)'(LOW_MB));
    end else begin
      mask_vld_o = !tgt_fifo_i;
    end
  end
endmodule

// File: rtl/can_mb_iflag.sv
module can_mb_iflag
  import can_iflag_pkg::*;
#(
  parameter int unsigned NUM_MB     = 32,
  parameter int unsigned LOW_MB     = 8,
  parameter int unsigned FILT_ELEMS = 8,
  parameter int unsigned FIFO_DEPTH = 6,
  parameter int unsigned WARN_LVL   = 4,
  parameter int unsigned FRAME_W    = 16,
  localparam int unsigned IDX_W     = $clog2(NUM_MB)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic [NUM_MB-1:0]  mb_done_i,
  input  logic               rx_push_i,
  input  logic [FRAME_W-1:0] rx_frame_i,
  input  logic               flag_wr_i,
  input  logic [NUM_MB-1:0]  flag_wdata_i,
  input  logic               tgt_fifo_i,
  input  logic [IDX_W-1:0]   tgt_idx_i,
  output logic [NUM_MB-1:0]  flag_o,
  output logic [FRAME_W-1:0] fifo_head_o,
  output logic               mask_vld_o,
  output logic [IDX_W-1:0]   mask_idx_o
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH+1);

  rx_mode_e          mode_q;
  logic              fifo_mode, mode_chg;
  logic [NUM_MB-1:0] clr;
  logic              push_req, pop_req;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              nonempty_next, pop_ok, warn_evt, ovf_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_MB;
    else         mode_q <= rx_mode_e'(fifo_en_i);
  end

  assign fifo_mode = (mode_q == MODE_FIFO);
  assign mode_chg  = (fifo_en_i != fifo_mode);
  assign clr       = flag_wr_i ? flag_wdata_i : '0;
  assign push_req  = rx_push_i && fifo_mode && !mode_chg;
  assign pop_req   = clr[AVAIL_BIT] && fifo_mode && !mode_chg;

  can_rxf_store #(
    .DEPTH   (FIFO_DEPTH),
    .WIDTH   (FRAME_W),
    .WARN_LVL(WARN_LVL)
  ) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (mode_chg),
    .push_i         (push_req),
    .data_i         (rx_frame_i),
    .pop_i          (pop_req),
    .head_o         (fifo_head_o),
    .count_o        (fifo_cnt),
    .nonempty_next_o(nonempty_next),
    .pop_ok_o       (pop_ok),
    .warn_evt_o     (warn_evt),
    .ovf_evt_o      (ovf_evt)
  );

  can_iflag_reg #(
    .NUM_MB(NUM_MB),
    .LOW_MB(LOW_MB)
  ) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_mode_i(fifo_mode),
    .mode_chg_i (mode_chg),
    .done_i     (mb_done_i),
    .clr_i      (clr),
    .avail_i    (nonempty_next && !pop_ok),
    .warn_evt_i (warn_evt),
    .ovf_evt_i  (ovf_evt),
    .flag_o     (flag_o)
  );

  can_mask_route #(
    .NUM_MB    (NUM_MB),
    .FILT_ELEMS(FILT_ELEMS),
    .LOW_MB    (LOW_MB)
  ) u_route (
    .fifo_mode_i(fifo_mode),
    .tgt_fifo_i (tgt_fifo_i),
    .tgt_idx_i  (tgt_idx_i),
    .mask_vld_o (mask_vld_o),
    .mask_idx_o (mask_idx_o)
  );

  assert_avail_on_push_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode && !mode_chg && rx_push_i && !clr[AVAIL_BIT]) |=> flag_o[AVAIL_BIT]);
  assert_pop_drops_avail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode && !mode_chg && clr[AVAIL_BIT] && flag_o[AVAIL_BIT]) |=> !flag_o[AVAIL_BIT]);
  assert_mb_mode_empty_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode |-> fifo_cnt == '0);
  assert_mask_mb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode && !tgt_fifo_i) |-> (mask_vld_o && mask_idx_o == tgt_idx_i));
  assert_mask_filt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode && tgt_fifo_i && tgt_idx_i < IDX_W'(FILT_ELEMS)) |-> mask_vld_o);
  assert_mask_low_mb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode && !tgt_fifo_i && tgt_idx_i < IDX_W'(LOW_MB)) |-> !mask_vld_o);
endmodule

// File: tb/tb_can_mb_iflag.sv
module tb_can_mb_iflag;
  localparam int NMB = 32;
  localparam int FW  = 16;
  localparam int DEP = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          fifo_en_i;
  logic [NMB-1:0] mb_done_i;
  logic          rx_push_i;
  logic [FW-1:0] rx_frame_i;
  logic          flag_wr_i;
  logic [NMB-1:0] flag_wdata_i;
  logic          tgt_fifo_i;
  logic [4:0]    tgt_idx_i;
  logic [NMB-1:0] flag_o;
  logic [FW-1:0] fifo_head_o;
  logic          mask_vld_o;
  logic [4:0]    mask_idx_o;

  always #4 clk_i = ~clk_i;

  can_mb_iflag dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .mb_done_i(mb_done_i),
    .rx_push_i(rx_push_i), .rx_frame_i(rx_frame_i), .flag_wr_i(flag_wr_i),
    .flag_wdata_i(flag_wdata_i), .tgt_fifo_i(tgt_fifo_i), .tgt_idx_i(tgt_idx_i),
    .flag_o(flag_o), .fifo_head_o(fifo_head_o), .mask_vld_o(mask_vld_o),
    .mask_idx_o(mask_idx_o)
  );

  int checks = 0;
  int fails  = 0;

  logic [NMB-1:0] m_flag;
  logic           m_mode;
  logic [FW-1:0]  m_q [DEP];
  int             m_cnt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic ev;
    if (!m_mode) chk("R2", flag_o, m_flag);
    else begin
      chk("R2", {8'h0, flag_o[31:8]}, {8'h0, m_flag[31:8]});
      chk("R4", {27'h0, flag_o[4:0]}, 32'h0);
      chk("R5", {31'h0, flag_o[5]}, {31'h0, m_flag[5]});
      chk("R7", {31'h0, flag_o[6]}, {31'h0, m_flag[6]});
      chk("R8", {31'h0, flag_o[7]}, {31'h0, m_flag[7]});
      if (m_cnt > 0) chk("R6", {16'h0, fifo_head_o}, {16'h0, m_q[0]});
    end
    if (m_mode) ev = tgt_fifo_i ? (tgt_idx_i < 8) : (tgt_idx_i >= 8);
    else        ev = !tgt_fifo_i;
    chk(m_mode ? "R11" : "R10", {31'h0, mask_vld_o}, {31'h0, ev});
    if (ev) chk(m_mode ? "R11" : "R10", {27'h0, mask_idx_o}, {27'h0, tgt_idx_i});
  endtask

  task automatic model_step();
    logic [NMB-1:0] clr;
    logic pop, ovf, warn;
    int cnt0;
    clr = flag_wr_i ? flag_wdata_i : '0;
    for (int i = 8; i < NMB; i++) m_flag[i] = mb_done_i[i] | (m_flag[i] & ~clr[i]);
    if (fifo_en_i != m_mode) begin
      m_mode = fifo_en_i;
      m_cnt  = 0;
      m_flag[7:0] = '0;
    end else if (!m_mode) begin
      for (int i = 0; i < 8; i++) m_flag[i] = mb_done_i[i] | (m_flag[i] & ~clr[i]);
    end else begin
      cnt0 = m_cnt;
      pop  = clr[5] && (m_cnt > 0);
      ovf  = 1'b0;
      if (pop) begin
        for (int k = 0; k < DEP-1; k++) m_q[k] = m_q[k+1];
        m_cnt--;
      end
      if (rx_push_i) begin
        if (cnt0 == DEP && !pop) ovf = 1'b1;
        else begin
          m_q[m_cnt] = rx_frame_i;
          m_cnt++;
        end
      end
      warn = (cnt0 == 3) && (m_cnt == 4);
      m_flag[4:0] = '0;
      m_flag[5]   = pop ? 1'b0 : (m_cnt != 0);
      m_flag[6]   = warn | (m_flag[6] & ~clr[6]);
      m_flag[7]   = ovf  | (m_flag[7] & ~clr[7]);
    end
  endtask

  // inputs are set just after a falling edge before this is called
  task automatic cycle();
    #1;
    check_outputs();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic drive(input logic en, input logic [NMB-1:0] done, input logic push,
                       input logic [FW-1:0] frame, input logic wr, input logic [NMB-1:0] wd);
    fifo_en_i    = en;
    mb_done_i    = done;
    rx_push_i    = push;
    rx_frame_i   = frame;
    flag_wr_i    = wr;
    flag_wdata_i = wd;
    tgt_fifo_i   = 1'($urandom);
    tgt_idx_i    = 5'($urandom);
    cycle();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_flag = '0; m_mode = 1'b0; m_cnt = 0;
    for (int k = 0; k < DEP; k++) m_q[k] = '0;
    rst_ni = 1'b0;
    fifo_en_i = 0; mb_done_i = '0; rx_push_i = 0; rx_frame_i = '0;
    flag_wr_i = 0; flag_wdata_i = '0; tgt_fifo_i = 0; tgt_idx_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", flag_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", flag_o, 32'h0);

    // R2/R3: set, then set and clear together
    drive(0, 32'h0000_0200, 0, '0, 0, '0);
    drive(0, 32'h0000_0200, 0, '0, 1, 32'h0000_0200);
    chk("R3", {31'h0, flag_o[9]}, 32'h1);
    drive(0, '0, 0, '0, 1, 32'h0000_0200);
    chk("R2", {31'h0, flag_o[9]}, 32'h0);

    // R12: pushes in buffer mode are dropped
    drive(0, '0, 1, 16'hAAAA, 0, '0);
    drive(1, '0, 0, '0, 0, '0);
    drive(1, '0, 0, '0, 0, '0);
    chk("R12", {31'h0, flag_o[5]}, 32'h0);

    // R5/R7/R8: fill past capacity
    for (int n = 0; n < 8; n++) drive(1, 32'h0000_00FF, 1, 16'h1000 + 16'(n), 0, '0);
    drive(1, '0, 0, '0, 1, 32'h0000_0040);
    drive(1, '0, 1, 16'h2000, 0, '0);
    chk("R7", {31'h0, flag_o[6]}, 32'h0);

    // R6: drain with releases, bit 5 drops one cycle each time
    for (int n = 0; n < 7; n++) begin
      drive(1, '0, 0, '0, 1, 32'h0000_0020);
      drive(1, '0, 0, '0, 0, '0);
    end

    // R9: flush on mode change, high flags kept
    drive(1, 32'h0000_0400, 1, 16'h3333, 0, '0);
    drive(0, '0, 0, '0, 0, '0);
    chk("R9", {24'h0, flag_o[7:0]}, 32'h0);
    chk("R9", {31'h0, flag_o[10]}, 32'h1);

    // random traffic
    begin
      logic en;
      en = 1'b0;
      for (int c = 0; c < 4000; c++) begin
        if ($urandom % 90 == 0) en = ~en;
        drive(en, $urandom & $urandom & $urandom, 1'($urandom % 2 == 0), 16'($urandom),
              1'($urandom % 3 == 0), ($urandom & $urandom) | (32'($urandom % 2) << 5));
      end
    end

    summary();
    $finish;
  end
endmodule